// File: doc/BRIEF.md
# Framed FPGA Configuration Streamer

This block configures an external FPGA over a byte-wide write port after a single start pulse. It first pulls the target's active-low program line low for a fixed reset interval. After releasing it, the block waits for the target's active-low init line to go high. It then writes a fixed eight-byte header, followed by the contents of a local byte ROM. The ROM data is cut into 21-byte payload frames, and each frame is wrapped with a leading marker, a trailing check byte and padding. Four startup bytes close the stream.

Between frames the block looks at the target's status lines again. The stream stops early if init drops, if the done line rises, or if the ROM has been fully read. Every byte is a one-cycle strobe, and at least a configurable number of idle cycles separates two strobes. The write port has no back-pressure: the target must accept each strobe as it is issued. The init and done inputs pass through a synchronizer before the block acts on them. The run ends with exactly one of two status flags set, success or error, and the flag stays set until the next start.

Top module: `cfgld_top`

## Requirements
- R1: After reset the block is idle: `prog_n`=1, `wr_stb`=0, `busy`=0, `cfg_ok`=0, `cfg_err`=0.
- R2: A `start` pulse while idle raises `busy`, clears both status flags and drives `prog_n` low for exactly RST_CYC clock cycles. After that `prog_n` returns high and stays high for the rest of the run.
- R3: No byte is written before `init_n` is high. If `init_n` is still low INIT_TMO cycles after `prog_n` rises, the run ends with `cfg_err` set and no byte written.
- R4: The stream opens with the eight header bytes 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B, in that order.
- R5: Each frame is 28 bytes: 0x4F, then 21 ROM bytes taken in ascending address order, then 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF. The ROM holds FRAMES*21 bytes, and the byte at address a is ((a*29) mod 256) XOR 0x5A.
- R6: A frame begins only if, at the boundary, `init_n` is high, `done_in` is low and unread ROM bytes remain. Otherwise no further frame is sent.
- R7: Whenever the header has been sent, the stream ends with exactly four 0xFF bytes, whether all frames went out or the stream stopped early.
- R8: The run ends (`busy` falls) with `cfg_ok` set only if the whole ROM was sent and `done_in` went high within DONE_TMO cycles after the last startup byte. In every other case it ends with `cfg_err` set. The two flags are never set together.
- R9: Each `wr_stb` pulse lasts one cycle. Two consecutive strobes are at least GAP+1 cycles apart, and exactly GAP+1 apart within the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin configuration |
| init_n | input | 1 | Target init status, low while the target is not ready |
| done_in | input | 1 | Target done status, high when configuration is complete |
| prog_n | output | 1 | Active-low program/reset line to the target |
| wr_stb | output | 1 | One-cycle write strobe for `wr_data` |
| wr_data | output | 8 | Byte written to the target |
| busy | output | 1 | High from start until the run ends |
| cfg_ok | output | 1 | Run ended successfully |
| cfg_err | output | 1 | Run ended in error |

## Verification
The frame-boundary decision and a status change on the target can land in the same cycle. In particular, `done_in` or `init_n` may move while the last padding byte of a frame is being written. The bench provokes this by switching the status line in the very cycle it observes strobe 36, the last byte of the first frame. It then judges the result from the captured byte stream: exactly 40 bytes must appear (header, one frame, four startup bytes), and the run must end with the error flag because ROM data was left over. The same method is applied to a status change right after the header, where the expected stream is 12 bytes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_WINIT, S_HDR, S_NEXT, S_FRM, S_TAIL, S_DWAIT
  } seq_st_t;

  localparam int HDR_LEN  = 8;
  localparam int PAY_LEN  = 21;
  localparam int FRM_LEN  = 28;
  localparam int TAIL_LEN = 4;

  function automatic logic [7:0] hdr_byte(input logic [2:0] i);
    case (i)
      3'd3:    hdr_byte = 8'h4F;
      3'd4:    hdr_byte = 8'h80;
      3'd5:    hdr_byte = 8'hAF;
      3'd6:    hdr_byte = 8'h9B;
      3'd7:    hdr_byte = 8'h4B;
      default: hdr_byte = 8'hFF;
    endcase
  endfunction

  // position 0 marker, 1..21 payload, 22 check, 23..27 padding
  function automatic logic [7:0] frm_byte(input logic [4:0] i, input logic [7:0] pay);
    if (i == 5'd0)                          frm_byte = 8'h4F;
    else if (i <= 5'd21)                    frm_byte = pay;
    else if (i == 5'd22 || i == 5'd24)      frm_byte = 8'h4B;
    else                                    frm_byte = 8'hFF;
  endfunction

  function automatic logic [7:0] rom_fn(input int a);
    logic [7:0] v;
    v = 8'(a * 29);
    rom_fn = v ^ 8'h5A;
  endfunction
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgld_pacer.sv
module cfgld_pacer #(
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ready
);
  generate
    if (GAP == 0) begin : g_nogap
      assign ready = 1'b1;
    end else begin : g_gap
      localparam int GW = $clog2(GAP + 1);
      logic [GW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (fire)       cnt <= GW'(GAP);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign ready = (cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/cfgld_rom.sv
module cfgld_rom #(
  parameter int DEPTH = 42,
  parameter int AW    = 6
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  import cfgld_pkg::*;
  always_comb begin
    if (int'(addr) < DEPTH) data = rom_fn(int'(addr));
    else                    data = 8'hFF;
  end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int NBYTES   = 42,
  parameter int AW       = 6,
  parameter int RST_CYC  = 2000,
  parameter int INIT_TMO = 500,
  parameter int DONE_TMO = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          init_hi,
  input  logic          done_hi,
  input  logic          ready,
  input  logic [7:0]    rom_data,
  output logic          fire,
  output logic [AW-1:0] rom_addr,
  output logic          prog_n,
  output logic          wr_stb,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic          cfg_ok,
  output logic          cfg_err
);
  localparam int M1   = (RST_CYC > INIT_TMO) ? RST_CYC : INIT_TMO;
  localparam int MAXC = (M1 > DONE_TMO) ? M1 : DONE_TMO;
  localparam int CW   = $clog2(MAXC + 1);

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic [4:0]    idx;
  logic          emit;
  logic [7:0]    nxt_byte;
  logic          all_read;

  assign all_read = (rom_addr == AW'(NBYTES));

  always_comb begin
    emit = ready && (st == S_HDR || st == S_FRM || st == S_TAIL);
    case (st)
      S_HDR:   nxt_byte = hdr_byte(idx[2:0]);
      S_FRM:   nxt_byte = frm_byte(idx, rom_data);
      default: nxt_byte = 8'hFF;
    endcase
  end
  assign fire = emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      rom_addr <= '0;
      prog_n   <= 1'b1;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
      busy     <= 1'b0;
      cfg_ok   <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (emit) begin
        wr_stb  <= 1'b1;
        wr_data <= nxt_byte;
      end
      case (st)
        S_IDLE: if (start) begin
          st       <= S_PROG;
          cnt      <= '0;
          prog_n   <= 1'b0;
          busy     <= 1'b1;
          cfg_ok   <= 1'b0;
          cfg_err  <= 1'b0;
          rom_addr <= '0;
        end
        S_PROG: begin
          if (cnt == CW'(RST_CYC - 1)) begin
            prog_n <= 1'b1;
            cnt    <= '0;
            st     <= S_WINIT;
          end else cnt <= cnt + 1'b1;
        end
        S_WINIT: begin
          if (init_hi) begin
            st  <= S_HDR;
            idx <= '0;
          end else if (cnt == CW'(INIT_TMO - 1)) begin
            cfg_err <= 1'b1;
            busy    <= 1'b0;
            st      <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_HDR: if (emit) begin
          if (idx == 5'(HDR_LEN - 1)) begin
            idx <= '0;
            st  <= S_NEXT;
          end else idx <= idx + 1'b1;
        end
        S_NEXT: if (ready) begin
          idx <= '0;
          if (init_hi && !done_hi && !all_read) st <= S_FRM;
          else                                  st <= S_TAIL;
        end
        S_FRM: if (emit) begin
          if (idx != 5'd0 && idx <= 5'(PAY_LEN)) rom_addr <= rom_addr + 1'b1;
          if (idx == 5'(FRM_LEN - 1)) begin
            idx <= '0;
            st  <= S_NEXT;
          end else idx <= idx + 1'b1;
        end
        S_TAIL: if (emit) begin
          if (idx == 5'(TAIL_LEN - 1)) begin
            idx <= '0;
            cnt <= '0;
            st  <= S_DWAIT;
          end else idx <= idx + 1'b1;
        end
        S_DWAIT: begin
          if (done_hi) begin
            cfg_ok  <= all_read;
            cfg_err <= !all_read;
            busy    <= 1'b0;
            st      <= S_IDLE;
          end else if (cnt == CW'(DONE_TMO - 1)) begin
            cfg_err <= 1'b1;
            busy    <= 1'b0;
            st      <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top #(
  parameter int FRAMES   = 2,
  parameter int RST_CYC  = 2000,
  parameter int INIT_TMO = 500,
  parameter int DONE_TMO = 50,
  parameter int GAP      = 2,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       init_n,
  input  logic       done_in,
  output logic       prog_n,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       busy,
  output logic       cfg_ok,
  output logic       cfg_err
);
  localparam int NBYTES = FRAMES * cfgld_pkg::PAY_LEN;
  localparam int AW     = $clog2(NBYTES + 1);

  logic          init_hi, done_hi, ready, fire;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data;

  cfgld_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sync_init (
    .clk(clk), .rst_n(rst_n), .d(init_n), .q(init_hi));
  cfgld_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d(done_in), .q(done_hi));

  cfgld_pacer #(.GAP(GAP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ready(ready));

  cfgld_rom #(.DEPTH(NBYTES), .AW(AW)) u_rom (
    .addr(rom_addr), .data(rom_data));

  cfgld_seq #(
    .NBYTES(NBYTES), .AW(AW), .RST_CYC(RST_CYC),
    .INIT_TMO(INIT_TMO), .DONE_TMO(DONE_TMO)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .init_hi(init_hi), .done_hi(done_hi), .ready(ready),
    .rom_data(rom_data), .fire(fire), .rom_addr(rom_addr),
    .prog_n(prog_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic prog_n,
  input logic wr_stb,
  input logic busy,
  input logic cfg_ok,
  input logic cfg_err
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && !wr_stb));

  a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !wr_stb);

  a_r9_one_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (GAP > 0)) |=> !wr_stb);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_err));

  a_r8_end_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cfg_ok ^ cfg_err));

  a_r2_flags_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!cfg_ok && !cfg_err));
endmodule

bind cfgld_top cfgld_chk #(.GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .wr_stb(wr_stb),
  .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err));

// File: tb/sim_cfgld_top.sv
module sim_cfgld_top;
  localparam int RST_CYC = 2000;
  localparam int GAP     = 2;
  localparam int FRAMES  = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic init_n = 1'b0, done_in = 1'b0;
  logic prog_n, wr_stb, busy, cfg_ok, cfg_err;
  logic [7:0] wr_data;

  always #2.5 clk = ~clk;

  cfgld_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init_n(init_n),
    .done_in(done_in), .prog_n(prog_n), .wr_stb(wr_stb),
    .wr_data(wr_data), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err));

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scenario knobs, read by the monitor
  bit  run = 0;
  int  hold, done_at, drop_at;
  int  nb, cyc, last_t, min_gap, hdr_bad, plow, rel;
  bit  dropped;
  logic [7:0] cap [0:127];

  always @(negedge clk) begin
    if (!run) begin
      done_in = 1'b0; init_n = 1'b0;
    end else begin
      cyc++;
      if (!prog_n) begin plow++; rel = 0; init_n = 1'b0; end
      else begin
        rel++;
        if (rel >= hold && !dropped) init_n = 1'b1;
      end
      if (wr_stb) begin
        if (nb < 128) cap[nb] = wr_data;
        if (nb > 0) begin
          if (cyc - last_t < min_gap) min_gap = cyc - last_t;
          if (nb < 8 && cyc - last_t != GAP + 1) hdr_bad++;
        end
        last_t = cyc;
        nb++;
        if (done_at != 0 && nb == done_at) done_in = 1'b1;
        if (drop_at != 0 && nb == drop_at) begin dropped = 1; init_n = 1'b0; end
      end
    end
  end

  function automatic logic [7:0] rom_b(int a);
    logic [7:0] v;
    v = 8'(a * 29);
    return v ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_b(int n, int f);
    logic [7:0] hdr [0:7];
    int k, fi;
    hdr = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    if (n < 8) return hdr[n];
    n -= 8;
    if (n < 28 * f) begin
      fi = n / 28; k = n % 28;
      if (k == 0) return 8'h4F;
      if (k <= 21) return rom_b(fi * 21 + k - 1);
      if (k == 22 || k == 24) return 8'h4B;
      return 8'hFF;
    end
    return 8'hFF;
  endfunction

  // hold, done_at, drop_at, frames expected (-1: none), ok expected
  localparam int NSC = 6;
  localparam int SC [NSC][5] = '{
    '{5,   68, 0,  2, 1},   // full load, done after tail
    '{600, 0,  0, -1, 0},   // init never rises: timeout
    '{5,   0,  0,  2, 0},   // done never rises
    '{5,   36, 0,  1, 0},   // done rises on last byte of frame 1
    '{5,   0,  36, 1, 0},   // init drops on last byte of frame 1
    '{5,   8,  0,  0, 0}    // done rises on last header byte
  };

  task automatic run_sc(int s);
    int f, exp_n, bad, first_bad, guard;
    hold = SC[s][0]; done_at = SC[s][1]; drop_at = SC[s][2];
    f = SC[s][3];
    nb = 0; cyc = 0; last_t = 0; min_gap = 1000; hdr_bad = 0;
    plow = 0; rel = 0; dropped = 0;
    run = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !prog_n && !cfg_ok && !cfg_err, "R2 start state",
        {busy, prog_n, cfg_ok, cfg_err}, 4'b1000);
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    exp_n = (f < 0) ? 0 : 8 + 28 * f + 4;
    chk(plow == RST_CYC, "R2 program low cycles", plow, RST_CYC);
    if (f < 0) chk(nb == 0, "R3 no bytes on init timeout", nb, 0);
    else if (f == FRAMES) chk(nb == exp_n, "R5 byte count", nb, exp_n);
    else chk(nb == exp_n, "R6 early stop byte count", nb, exp_n);
    bad = 0; first_bad = -1;
    for (int i = 0; i < nb && i < exp_n && i < 128; i++)
      if (cap[i] !== exp_b(i, f)) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, "R4 R5 R7 stream content", first_bad,
        (first_bad < 0) ? 0 : int'(exp_b(first_bad, f)));
    if (f >= 0) begin
      chk(cap[exp_n-1] == 8'hFF && cap[exp_n-4] == 8'hFF, "R7 startup bytes",
          cap[exp_n-1], 8'hFF);
      chk(min_gap >= GAP + 1, "R9 strobe spacing", min_gap, GAP + 1);
      chk(hdr_bad == 0, "R9 header spacing exact", hdr_bad, 0);
    end
    chk(cfg_ok == SC[s][4], "R8 ok flag", cfg_ok, SC[s][4]);
    chk(cfg_err == !SC[s][4], "R8 err flag", cfg_err, !SC[s][4]);
    chk(!busy && prog_n, "R8 idle after run", busy, 0);
    run = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prog_n === 1'b1, "R1 prog_n", prog_n, 1);
    chk(wr_stb === 1'b0, "R1 wr_stb", wr_stb, 0);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(cfg_ok === 1'b0 && cfg_err === 1'b0, "R1 flags", {cfg_ok, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(prog_n && !busy && !wr_stb, "R1 idle after release", busy, 0);
    for (int s = 0; s < NSC; s++) run_sc(s);
    // R2: status from an error run is cleared by the next start, then full load passes
    run_sc(0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule